// File: doc/BRIEF.md
# Asynchronous 8/16-Bit Register Port

This block is the host-facing register port of a network controller. A processor reaches a small register file through a 6-bit address, active-low chip select, read and write strobes, and a 16-bit data path. The data path is split into an input, an output and an output enable, which the pad ring joins into one bidirectional bus. A static width input selects a 16-bit port or an 8-bit port. In 8-bit mode the lowest address bit picks one byte of a 16-bit register. In 16-bit mode, two active-low byte enables choose which byte lanes a write updates.

The strobes are asynchronous to the internal clock. Each one passes through a two-flop synchronizer, and the block acts on the deasserting (rising) edge of a strobe seen in the clock domain. Two event channels, one for transmit and one for receive, collect pulses from external event inputs into status registers. The interrupt output stays high while any status bit is set whose mask bit is also set. Reading a status register clears the bytes that were read. An event that lands in the same clock as that clear is kept.

The asynchronous reset zeroes the masks, the status registers and the synchronizers. The station-address words and the hash-filter words keep their contents through reset.

Top module: `cfg_reg_port`

## Requirements
- R1: While cs_n is high, a write strobe changes no register, and a read strobe leaves dq_oe low.
- R2: A write takes effect only after wr_n returns high. While wr_n is held low the addressed register keeps its old value.
- R3: dq_oe is 1 exactly while cs_n and rd_n are both 0. dq_out is 0 whenever dq_oe is 0.
- R4: With bus16=1, the word index is addr[4:0] and reads return all 16 bits of the word.
- R5: With bus16=0, the word index is addr[5:1] and addr[0] selects the byte (0 = bits 7:0, 1 = bits 15:8). Write data comes from dq_in[7:0], and reads return the byte on dq_out[7:0] with dq_out[15:8]=0.
- R6: In 16-bit mode, be_n[0]=0 lets a write update bits 7:0 and be_n[1]=0 lets it update bits 15:8. A lane whose enable is 1 keeps its value.
- R7: irq is 1 while (tx status & tx mask) or (rx status & rx mask) is nonzero. It stays 1 until the status register holding the cause is read.
- R8: Every clock in which an event input bit is 1 sets the matching status bit. When rd_n returns high, reading a status word clears the bytes that were read (both bytes in 16-bit mode, the selected byte in 8-bit mode). An event bit arriving in the clock of that clear stays set.
- R9: rst_n low zeroes both masks and both status registers. Words 0 to 6 keep their contents.
- R10: Status words are read-only. A write to word 9 or word 10 has no effect.
- R11: Word map: words 0-2 hold the station address, words 3-6 the hash filter, word 7 the tx mask, word 8 the rx mask, word 9 the tx status and word 10 the rx status. Any other word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; data is taken when it rises |
| addr | input | 6 | Register address |
| bus16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| be_n | input | 2 | Active-low byte-lane enables for 16-bit writes |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data to the bus |
| dq_oe | output | 1 | Enables the bus output driver |
| tx_evt | input | 16 | Transmit event pulses, one per status bit |
| rx_evt | input | 16 | Receive event pulses, one per status bit |
| irq | output | 1 | Interrupt, high while an unmasked status bit is set |

## Verification
The hardest case to reach from the ports is an event arriving in exactly the clock in which a status read clears the register. The clear comes from the synchronized rising edge of rd_n, two clocks after the pin rises. The stimulus counts those two clock edges after releasing rd_n and pulses the event input for that one clock. A second read must then show the new bit and not the bit that was cleared. Holding wr_n low for many clocks with a pending status bit shows that the mask takes effect only on the strobe's rise, because irq stays low until the rise.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int DW         = 16;
    localparam int LANES      = DW / 8;
    localparam int KEEP_WORDS = 7;   // station address 0..2, hash 3..6
    localparam int IDX_MASK0  = 7;   // tx mask, rx mask follows
    localparam int IDX_STAT0  = 9;   // tx status, rx status follows
    localparam int NCH        = 2;
    localparam int S_CS       = 0;
    localparam int S_RD       = 1;
    localparam int S_WR       = 2;
    localparam int NSTRB      = 3;

    typedef logic [DW-1:0]    word_t;
    typedef logic [LANES-1:0] lane_t;
endpackage

// File: rtl/rp_strobe_sync.sv
module rp_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] act,
    output logic [N-1:0] done
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = strb_n;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign act  = ~r_q.s2;
    assign done = r_q.s2 & ~r_q.s3;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((done & $past(done)) == '0)); // R2
endmodule

// File: rtl/rp_keep_file.sv
module rp_keep_file
    import rp_pkg::*;
#(
    parameter int WORDS = KEEP_WORDS,
    parameter int IW    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IW-1:0]          widx,
    input  lane_t                  wlanes,
    input  word_t                  wdata,
    output word_t [WORDS-1:0]      words
);
    word_t [WORDS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < WORDS; w++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we && (widx == IW'(w)) && wlanes[l])
                    mem_d[w][l*8 +: 8] = wdata[l*8 +: 8];
            end
        end
    end

    // No reset: contents survive rst_n.
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign words = mem_q;

    AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)); // R2
endmodule

// File: rtl/rp_event_reg.sv
module rp_event_reg
    import rp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mask_we,
    input  lane_t wlanes,
    input  word_t wdata,
    input  lane_t clr_lanes,
    input  word_t evt,
    output word_t stat,
    output word_t mask,
    output logic  hit
);
    typedef struct packed {
        word_t mask;
        word_t stat;
    } ev_t;

    ev_t r_d, r_q;
    word_t clr_bits;

    always_comb begin
        r_d = r_q;
        for (int l = 0; l < LANES; l++) begin
            clr_bits[l*8 +: 8] = {8{clr_lanes[l]}};
            if (mask_we && wlanes[l])
                r_d.mask[l*8 +: 8] = wdata[l*8 +: 8];
        end
        r_d.stat = (r_q.stat & ~clr_bits) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.stat;
    assign mask = r_q.mask;
    assign hit  = |(r_q.stat & r_q.mask);

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((r_q.stat & $past(evt)) == $past(evt))); // R8
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lanes[0] && (evt[7:0] == 8'h00)) |=> (r_q.stat[7:0] == 8'h00)); // R8
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lanes == '0) |=> ((r_q.stat & $past(r_q.stat)) == $past(r_q.stat))); // R7
endmodule

// File: rtl/cfg_reg_port.sv
module cfg_reg_port
    import rp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          bus16,
    input  logic [LANES-1:0] be_n,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DW-1:0] tx_evt,
    input  logic [DW-1:0] rx_evt,
    output logic          irq
);
    localparam int IW  = AW - 1;
    localparam int KIW = $clog2(KEEP_WORDS);

    logic [NSTRB-1:0] s_act, s_done;
    logic             wr_go, rd_go;
    logic [IW-1:0]    widx;
    lane_t            wlanes, rlanes;
    word_t            wdata, rword;
    word_t [KEEP_WORDS-1:0] keep;
    word_t            ch_evt  [NCH];
    word_t            ch_stat [NCH];
    word_t            ch_mask [NCH];
    logic [NCH-1:0]   ch_hit;

    rp_strobe_sync #(.N(NSTRB)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({wr_n, rd_n, cs_n}),
        .act    (s_act),
        .done   (s_done)
    );

    assign wr_go = s_done[S_WR] & s_act[S_CS];
    assign rd_go = s_done[S_RD] & s_act[S_CS];

    // Address decode and byte-lane steering for both bus widths.
    always_comb begin
        if (bus16) begin
            widx   = addr[IW-1:0];
            wlanes = ~be_n;
            rlanes = '1;
            wdata  = dq_in;
        end else begin
            widx   = addr[AW-1:1];
            wlanes = lane_t'(1) << addr[0];
            rlanes = lane_t'(1) << addr[0];
            wdata  = {LANES{dq_in[7:0]}};
        end
    end

    rp_keep_file #(.WORDS(KEEP_WORDS), .IW(IW)) u_keep (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_go && (widx < IW'(KEEP_WORDS))),
        .widx   (widx),
        .wlanes (wlanes),
        .wdata  (wdata),
        .words  (keep)
    );

    assign ch_evt[0] = tx_evt;
    assign ch_evt[1] = rx_evt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic  mwe;
        lane_t clr;
        assign mwe = wr_go && (widx == IW'(IDX_MASK0 + c));
        assign clr = (rd_go && (widx == IW'(IDX_STAT0 + c))) ? rlanes : '0;

        rp_event_reg u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .mask_we   (mwe),
            .wlanes    (wlanes),
            .wdata     (wdata),
            .clr_lanes (clr),
            .evt       (ch_evt[c]),
            .stat      (ch_stat[c]),
            .mask      (ch_mask[c]),
            .hit       (ch_hit[c])
        );
    end

    always_comb begin
        rword = '0;
        if (widx < IW'(KEEP_WORDS)) rword = keep[widx[KIW-1:0]];
        for (int c = 0; c < NCH; c++) begin
            if (widx == IW'(IDX_MASK0 + c)) rword = ch_mask[c];
            if (widx == IW'(IDX_STAT0 + c)) rword = ch_stat[c];
        end
    end

    assign dq_oe  = ~cs_n & ~rd_n;
    assign dq_out = !dq_oe ? '0 :
                    bus16  ? rword :
                             {{(DW-8){1'b0}}, (addr[0] ? rword[15:8] : rword[7:0])};
    assign irq    = |ch_hit;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_go && !wr_go) |=> irq); // R7
    AST_NO_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_done[S_WR] && !s_act[S_CS]) |=> ($stable(keep) && $stable(ch_mask[0]) && $stable(ch_mask[1]))); // R1
endmodule

// File: tb/test_cfg_reg_port.sv
`timescale 1ns/1ps
module test_cfg_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [5:0]  addr = '0;
    logic        bus16 = 1'b1;
    logic [1:0]  be_n = 2'b11;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] tx_evt = '0, rx_evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] rd_got;
    event        rd_ev;

    always #2 clk = ~clk;

    cfg_reg_port i_cfg_reg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .bus16(bus16), .be_n(be_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .tx_evt(tx_evt), .rx_evt(rx_evt), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d,
                             input logic [1:0] be, input logic sel);
        @(negedge clk);
        cs_n = ~sel; addr = a; dq_in = d; be_n = be; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; be_n = 2'b11;
        repeat (2) @(negedge clk);
    endtask

    // Driver: pushes the expected word, samples the bus, hands it to the monitor.
    task automatic bus_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; addr = a; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_got = dq_out;
        -> rd_ev;
        chk({tag, " oe"}, {15'd0, dq_oe}, 16'd1);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares each sampled read against the scoreboard.
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, got %h expected none", rd_got);
            end else begin
                chk(tag_q.pop_front(), rd_got, exp_q.pop_front());
            end
        end
    end

    task automatic pulse_evt(input logic rx, input logic [15:0] v);
        @(negedge clk);
        if (rx) rx_evt = v; else tx_evt = v;
        @(negedge clk);
        rx_evt = '0; tx_evt = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state
        chk("R3 reset oe", {15'd0, dq_oe}, 16'd0);
        chk("R3 reset dq_out", dq_out, 16'h0000);
        chk("R7 reset irq", {15'd0, irq}, 16'd0);
        bus_read(6'd7, 16'h0000, "R9 tx mask after reset");
        bus_read(6'd10, 16'h0000, "R9 rx status after reset");

        // 16-bit writes and readback
        bus_write(6'd0, 16'hA5C3, 2'b00, 1'b1);
        bus_read(6'd0, 16'hA5C3, "R4 R11 station word0");
        bus_write(6'd1, 16'h1111, 2'b00, 1'b1);
        bus_write(6'd1, 16'hBEEF, 2'b00, 1'b0);
        bus_read(6'd1, 16'h1111, "R1 write without cs ignored");

        // Read strobe without chip select
        @(negedge clk);
        addr = 6'd0; rd_n = 1'b0; cs_n = 1'b1;
        #1;
        chk("R1 R3 oe low without cs", {15'd0, dq_oe}, 16'd0);
        chk("R3 dq_out zero without cs", dq_out, 16'h0000);
        @(negedge clk);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);

        // Byte enables
        bus_write(6'd3, 16'h1234, 2'b00, 1'b1);
        bus_write(6'd3, 16'hABCD, 2'b10, 1'b1);
        bus_read(6'd3, 16'h12CD, "R6 low lane only");
        bus_write(6'd3, 16'h5600, 2'b01, 1'b1);
        bus_read(6'd3, 16'h56CD, "R6 high lane only");

        // Write takes effect on the strobe rise; irq follows
        pulse_evt(1'b0, 16'h0001);
        chk("R7 masked event no irq", {15'd0, irq}, 16'd0);
        @(negedge clk);
        cs_n = 1'b0; addr = 6'd7; dq_in = 16'h0001; be_n = 2'b00; wr_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 mask not applied while wr_n low", {15'd0, irq}, 16'd0);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 R7 irq after wr_n rise", {15'd0, irq}, 16'd1);
        cs_n = 1'b1; be_n = 2'b11;
        repeat (2) @(negedge clk);
        chk("R7 irq held before status read", {15'd0, irq}, 16'd1);
        bus_read(6'd9, 16'h0001, "R8 tx status value");
        chk("R7 R8 irq clears after status read", {15'd0, irq}, 16'd0);

        // Status is read-only
        bus_write(6'd9, 16'hFFFF, 2'b00, 1'b1);
        bus_read(6'd9, 16'h0000, "R10 status write ignored");

        // 8-bit mode
        bus16 = 1'b0;
        bus_write(6'd4, 16'h0077, 2'b11, 1'b1);
        bus_write(6'd5, 16'h0088, 2'b11, 1'b1);
        bus_read(6'd5, 16'h0088, "R5 8-bit high byte read");
        pulse_evt(1'b1, 16'h0301);
        bus_read(6'd20, 16'h0001, "R5 R8 8-bit rx status low byte");
        bus_read(6'd21, 16'h0003, "R8 high byte kept by low-byte read");
        bus_read(6'd20, 16'h0000, "R8 low byte cleared");
        bus_read(6'd21, 16'h0000, "R8 high byte cleared");
        bus16 = 1'b1;
        bus_read(6'd2, 16'h8877, "R5 8-bit writes assembled");

        // Event in the same clock as the clear
        pulse_evt(1'b0, 16'h0001);
        chk("R7 unmasked event raises irq", {15'd0, irq}, 16'd1);
        @(negedge clk);
        cs_n = 1'b0; addr = 6'd9; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back(16'h0001);
        tag_q.push_back("R8 tx status before clear");
        rd_got = dq_out;
        -> rd_ev;
        rd_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_evt = 16'h0010;
        @(negedge clk);
        tx_evt = '0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(6'd9, 16'h0010, "R8 event in clear clock kept");

        // Unmapped word
        bus_read(6'd12, 16'h0000, "R11 unmapped word reads zero");

        // Selective reset
        bus_write(6'd8, 16'hFFFF, 2'b00, 1'b1);
        bus_read(6'd8, 16'hFFFF, "R11 rx mask word");
        pulse_evt(1'b1, 16'h0004);
        chk("R7 rx event irq", {15'd0, irq}, 16'd1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 irq zero after reset", {15'd0, irq}, 16'd0);
        bus_read(6'd0, 16'hA5C3, "R9 station word kept");
        bus_read(6'd3, 16'h56CD, "R9 hash word kept");
        bus_read(6'd8, 16'h0000, "R9 rx mask cleared");
        bus_read(6'd10, 16'h0000, "R9 rx status cleared");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule